// File: doc/BRIEF.md
# Memory-Mapped Sample Ring Bridge

This block sits on a synchronous host memory bus and looks to the host processor like a small memory device with four word locations. The host clock drives the block directly, so strobes are sampled on clock edges without any edge detection. A read of one location takes the oldest captured ADC sample out of an on-chip ring. A write to another location adds a word to a second on-chip ring that feeds a DAC. The two remaining locations hold a status word and an interrupt threshold.

The ADC side enters through a valid/ready stream. A sample transfers on a clock edge where both `adc_valid_i` and `adc_ready_o` are high. Ready drops while the capture ring is full, and the producer must then hold its sample until ready returns. The DAC side leaves through a valid/ready stream as well. `dac_valid_o` is high whenever the playback ring holds a word, and the word moves out on an edge where `dac_ready_i` is also high. A level interrupt tells the host that enough samples are waiting, so host DMA can drain them as a block.

Addresses are word indices: index 0 is byte offset 0x0, index 1 is 0x4, index 2 is 0x8 and index 3 is 0xC.

Top module: `ringbuf_membridge`

## Requirements
- R1: After reset these values hold:
  - `rdata_o` is 0 and `irq_o` is low.
  - `adc_ready_o` is high and `dac_valid_o` is low.
  - The status word reports a fill count of 0, a free count equal to the ring depth, and both flags clear.
  - The threshold register reads back as half the ring depth.
- R2: A read at word index 0 returns the oldest stored ADC sample, zero-extended from bit 0. The sample is removed from the ring, and samples leave in arrival order.
- R3: A read at index 0 while the ADC ring is empty returns 0, leaves the fill count unchanged and sets the underflow flag. The underflow flag is status bit 17.
- R4: `adc_ready_o` is low exactly while the ADC ring holds depth samples. A sample offered while ready is low is not stored.
- R5: A write at index 1 stores the low DAC-width bits of the write data in the playback ring. `dac_valid_o` and `dac_data_o` present the oldest stored word, which is removed on an edge with valid and ready both high.
- R6: A write at index 1 while the playback ring is full discards the word and sets the overflow flag. The overflow flag is status bit 16.
- R7: A read at index 2 returns the status word, laid out as follows:
  - bits 7:0 hold the ADC fill count;
  - bits 15:8 hold the playback free count;
  - bit 16 holds the overflow flag;
  - bit 17 holds the underflow flag;
  - all other bits read as 0.
  The flags are sticky. A write at index 2 clears each flag whose bit is 1 in the write data.
- R8: A write at index 3 loads the full write word into the threshold register. A read at index 3 returns that word. A read at index 1 returns 0, and a write at index 0 has no effect.
- R9: `irq_o` is high exactly while the ADC fill count is at or above the threshold register value.
- R10: Read data appears on `rdata_o` in the clock cycle after an edge where `cs_i` and `rd_i` are both high, and is 0 in every other cycle. Strobes are ignored while `cs_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| word_addr_i | input | ADDR_W | Word index of the access |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Registered read data |
| irq_o | output | 1 | Level interrupt for ADC fill at or above the threshold |
| adc_valid_i | input | 1 | ADC sample offered |
| adc_data_i | input | SAMPLE_W | ADC sample value |
| adc_ready_o | output | 1 | Capture ring can accept a sample |
| dac_valid_o | output | 1 | Playback word available |
| dac_data_o | output | DAC_W | Oldest playback word |
| dac_ready_i | input | 1 | DAC consumer takes the word |

## Verification
The bench builds the block with a ring depth of 8 (DEPTH_LOG2 = 3), keeping the default widths: 32-bit bus, 18-bit samples and 16-bit DAC words. At that depth a few accesses fill either ring, so back-pressure at full, dropped DAC writes, empty-ring reads and every threshold crossing occur many times in the random phase. Random thresholds from 0 to 10 include values above the depth. This exercises both an interrupt that is always on and one that can never fire.

// File: rtl/membridge_pkg.sv
package membridge_pkg;

  // Word slots in the host address space
  localparam int SLOT_ADC  = 0;
  localparam int SLOT_DAC  = 1;
  localparam int SLOT_STAT = 2;
  localparam int SLOT_THR  = 3;
  localparam int N_SLOTS   = 4;

  // Status word field positions
  localparam int STAT_FILL_LSB = 0;
  localparam int STAT_FREE_LSB = 8;
  localparam int STAT_OVF_BIT  = 16;
  localparam int STAT_UDF_BIT  = 17;

  // Qualified bus strobes, one per action the block takes
  typedef struct packed {
    logic adc_rd;
    logic dac_wr;
    logic stat_rd;
    logic stat_wr;
    logic thr_rd;
    logic thr_wr;
  } strobes_t;

endpackage

// File: rtl/membridge_ring.sv
module membridge_ring #(
  parameter int W  = 18,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [AW:0]   fill_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   fill_q;
  logic          do_push, do_pop;

  assign full_o  = (fill_q == (AW+1)'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rp_q];
  assign fill_o  = fill_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/membridge_decode.sv
module membridge_decode
  import membridge_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  output strobes_t          stb_o
);
  logic [N_SLOTS-1:0] hit;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign hit[g] = cs_i && (word_addr_i == ADDR_W'(g));
  end

  always_comb begin
    stb_o.adc_rd  = hit[SLOT_ADC]  && rd_i;
    stb_o.dac_wr  = hit[SLOT_DAC]  && wr_i;
    stb_o.stat_rd = hit[SLOT_STAT] && rd_i;
    stb_o.stat_wr = hit[SLOT_STAT] && wr_i;
    stb_o.thr_rd  = hit[SLOT_THR]  && rd_i;
    stb_o.thr_wr  = hit[SLOT_THR]  && wr_i;
  end
endmodule

// File: rtl/ringbuf_membridge.sv
module ringbuf_membridge
  import membridge_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int ADDR_W     = 2,
  parameter int SAMPLE_W   = 18,
  parameter int DAC_W      = 16,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   word_addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic                irq_o,
  input  logic                adc_valid_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                adc_ready_o,
  output logic                dac_valid_o,
  output logic [DAC_W-1:0]    dac_data_o,
  input  logic                dac_ready_i
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int CNT_W = DEPTH_LOG2 + 1;   // must stay <= 8 for the status layout

  strobes_t             stb;
  logic [SAMPLE_W-1:0]  adc_head;
  logic [CNT_W-1:0]     adc_fill, dac_fill, dac_free;
  logic                 adc_full, adc_empty, dac_full, dac_empty;
  logic                 ovf_q, udf_q;
  logic [BUS_W-1:0]     thr_q;
  logic [BUS_W-1:0]     stat_word;

  membridge_decode #(.ADDR_W(ADDR_W)) decode_i (
    .cs_i        (cs_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .word_addr_i (word_addr_i),
    .stb_o       (stb)
  );

  membridge_ring #(.W(SAMPLE_W), .AW(DEPTH_LOG2)) adc_ring_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (adc_valid_i),
    .push_data_i (adc_data_i),
    .pop_i       (stb.adc_rd),
    .head_o      (adc_head),
    .fill_o      (adc_fill),
    .full_o      (adc_full),
    .empty_o     (adc_empty)
  );

  membridge_ring #(.W(DAC_W), .AW(DEPTH_LOG2)) dac_ring_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (stb.dac_wr),
    .push_data_i (wdata_i[DAC_W-1:0]),
    .pop_i       (dac_ready_i),
    .head_o      (dac_data_o),
    .fill_o      (dac_fill),
    .full_o      (dac_full),
    .empty_o     (dac_empty)
  );

  assign adc_ready_o = !adc_full;
  assign dac_valid_o = !dac_empty;
  assign dac_free    = CNT_W'(DEPTH) - dac_fill;
  assign irq_o       = (BUS_W'(adc_fill) >= thr_q);

  always_comb begin
    stat_word = '0;
    stat_word[STAT_FILL_LSB +: CNT_W] = adc_fill;
    stat_word[STAT_FREE_LSB +: CNT_W] = dac_free;
    stat_word[STAT_OVF_BIT]           = ovf_q;
    stat_word[STAT_UDF_BIT]           = udf_q;
  end

  // Sticky flags: a fresh event in the same cycle wins over a clear
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (stb.stat_wr && wdata_i[STAT_OVF_BIT]) ovf_q <= 1'b0;
      if (stb.stat_wr && wdata_i[STAT_UDF_BIT]) udf_q <= 1'b0;
      if (stb.dac_wr && dac_full)               ovf_q <= 1'b1;
      if (stb.adc_rd && adc_empty)              udf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         thr_q <= BUS_W'(DEPTH / 2);
    else if (stb.thr_wr) thr_q <= wdata_i;
  end

  // Registered read path: data valid one clock after the strobe
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      if (stb.adc_rd && !adc_empty) rdata_o <= BUS_W'(adc_head);
      if (stb.stat_rd)              rdata_o <= stat_word;
      if (stb.thr_rd)               rdata_o <= thr_q;
    end
  end
endmodule

// File: rtl/membridge_checker.sv
module membridge_checker
  import membridge_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CNT_W = 5,
  parameter int DEPTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             rd_i,
  input strobes_t         stb,
  input logic [BUS_W-1:0] rdata_o,
  input logic             irq_o,
  input logic             adc_ready_o,
  input logic             dac_valid_o,
  input logic [CNT_W-1:0] adc_fill,
  input logic [CNT_W-1:0] dac_free,
  input logic             ovf_q,
  input logic             udf_q
);
  assert_rdata_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |=> (rdata_o == '0));

  assert_ready_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_fill == CNT_W'(DEPTH)) |-> !adc_ready_o);

  assert_fill_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_fill <= CNT_W'(DEPTH));

  assert_underflow_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb.adc_rd && adc_fill == '0) |=> udf_q);

  assert_overflow_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb.dac_wr && dac_free == '0) |=> ovf_q);

  assert_dac_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb.dac_wr |=> dac_valid_o);

  assert_irq_drop_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(stb.adc_rd || stb.thr_wr));
endmodule

bind ringbuf_membridge membridge_checker #(
  .BUS_W (BUS_W),
  .CNT_W (CNT_W),
  .DEPTH (DEPTH)
) checker_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_i),
  .rd_i        (rd_i),
  .stb         (stb),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .adc_ready_o (adc_ready_o),
  .dac_valid_o (dac_valid_o),
  .adc_fill    (adc_fill),
  .dac_free    (dac_free),
  .ovf_q       (ovf_q),
  .udf_q       (udf_q)
);

// File: tb/ringbuf_membridge_tb_top.sv
module ringbuf_membridge_tb_top;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 2;
  localparam int SAMPLE_W = 18;
  localparam int DAC_W = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int WATCHDOG_NS = 4 * 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BUS_W-1:0] wdata = '0;
  logic [BUS_W-1:0] rdata;
  logic irq;
  logic adc_valid = 0;
  logic [SAMPLE_W-1:0] adc_data = '0;
  logic adc_ready;
  logic dac_valid;
  logic [DAC_W-1:0] dac_data;
  logic dac_ready = 0;

  always #2 clk = ~clk;

  ringbuf_membridge #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W),
    .DAC_W(DAC_W), .DEPTH_LOG2(AW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .word_addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .adc_valid_i(adc_valid), .adc_data_i(adc_data), .adc_ready_o(adc_ready),
    .dac_valid_o(dac_valid), .dac_data_o(dac_data), .dac_ready_i(dac_ready)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference model
  int unsigned adcq[$];
  int unsigned dacq[$];
  bit ovf = 0, udf = 0;
  logic [BUS_W-1:0] thr = BUS_W'(DEPTH / 2);

  function automatic logic [BUS_W-1:0] exp_status();
    logic [BUS_W-1:0] s;
    s = '0;
    s[7:0]  = 8'(adcq.size());
    s[15:8] = 8'(DEPTH - dacq.size());
    s[16]   = ovf;
    s[17]   = udf;
    return s;
  endfunction

  task automatic check(input string req, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_side();
    check("R9 irq level", {31'b0, irq}, {31'b0, (BUS_W'(adcq.size()) >= thr)});
    check("R4 adc_ready", {31'b0, adc_ready}, {31'b0, adcq.size() < DEPTH});
    check("R5 dac_valid", {31'b0, dac_valid}, {31'b0, dacq.size() > 0});
  endtask

  task automatic do_read(input int a, input string req);
    logic [BUS_W-1:0] exp;
    case (a)
      0: if (adcq.size() == 0) begin exp = '0; udf = 1; end
         else exp = BUS_W'(adcq.pop_front());
      1: exp = '0;
      2: exp = exp_status();
      default: exp = thr;
    endcase
    @(negedge clk); cs = 1; rd = 1; addr = ADDR_W'(a);
    @(negedge clk); cs = 0; rd = 0;
    check(req, rdata, exp);
    check_side();
  endtask

  task automatic do_write(input int a, input logic [BUS_W-1:0] d);
    case (a)
      0: ;
      1: if (dacq.size() < DEPTH) dacq.push_back(int'(d[DAC_W-1:0])); else ovf = 1;
      2: begin if (d[16]) ovf = 0; if (d[17]) udf = 0; end
      default: thr = d;
    endcase
    @(negedge clk); cs = 1; wr = 1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk); cs = 0; wr = 0;
    check_side();
  endtask

  task automatic adc_push(input logic [SAMPLE_W-1:0] s);
    bit accept;
    accept = adcq.size() < DEPTH;
    @(negedge clk); adc_valid = 1; adc_data = s;
    check("R4 ready before push", {31'b0, adc_ready}, {31'b0, accept});
    @(negedge clk); adc_valid = 0;
    if (accept) adcq.push_back(int'(s));
    check_side();
  endtask

  task automatic dac_take();
    @(negedge clk); dac_ready = 1;
    check("R5 valid on take", {31'b0, dac_valid}, {31'b0, dacq.size() > 0});
    if (dacq.size() > 0) check("R5 dac word order", BUS_W'(dac_data), BUS_W'(dacq[0]));
    @(negedge clk); dac_ready = 0;
    if (dacq.size() > 0) void'(dacq.pop_front());
    check_side();
  endtask

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", rdata, '0);
    check("R1 irq", {31'b0, irq}, '0);
    check("R1 adc_ready", {31'b0, adc_ready}, 32'd1);
    check("R1 dac_valid", {31'b0, dac_valid}, '0);
    do_read(2, "R1 status");
    do_read(3, "R1 threshold");

    // R10 strobes without chip select are ignored
    adc_push(18'h1234);
    @(negedge clk); rd = 1; wr = 1; addr = 0; wdata = 32'hFFFF_FFFF;
    @(negedge clk); rd = 0; wr = 0;
    check("R10 no cs rdata", rdata, '0);
    do_read(2, "R10 status unchanged");
    @(negedge clk);
    check("R10 rdata idle", rdata, '0);

    // R4 fill ADC ring past full; R9 threshold crossing
    for (int i = 0; i < DEPTH + 2; i++) adc_push(SAMPLE_W'(18'h20000 + i));
    do_read(2, "R7 status at full");
    // R2 drain in order; R3 empty read
    for (int i = 0; i < DEPTH + 1; i++) do_read(0, "R2 adc order");
    do_read(0, "R3 empty read");
    do_read(2, "R3 underflow flag");

    // R6 fill DAC ring past full; R8 read of DAC slot and write of ADC slot
    for (int i = 0; i < DEPTH + 1; i++) do_write(1, BUS_W'(32'hABCD_0000 + i));
    do_read(2, "R6 overflow flag");
    do_read(1, "R8 dac slot reads zero");
    do_write(0, 32'h5A5A_5A5A);
    do_read(2, "R8 adc slot write ignored");
    // R7 write one to clear each flag separately
    do_write(2, 32'h0001_0000);
    do_read(2, "R7 clear overflow");
    do_write(2, 32'h0002_0000);
    do_read(2, "R7 clear underflow");
    for (int i = 0; i < DEPTH + 1; i++) dac_take();

    // R8 threshold readback, R9 threshold 0 and above depth
    do_write(3, 32'd0);
    do_read(3, "R8 threshold zero");
    do_write(3, 32'hDEAD_BEEF);
    do_read(3, "R8 threshold full word");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: adc_push(SAMPLE_W'($urandom));
        2, 3: do_read(0, "R2 random adc read");
        4:    do_write(1, $urandom);
        5:    dac_take();
        6:    do_read(2, "R7 random status");
        7:    do_write(3, BUS_W'($urandom_range(0, 10)));
        8:    do_write(2, BUS_W'($urandom_range(0, 3)) << 16);
        default: do_read(int'($urandom_range(1, 3)), "R8 random slot read");
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule